// File: doc/BRIEF.md
# Capture DMA Instruction Sequencer

This block runs a short program of two-word instructions that it reads from memory. The program moves captured audio words from an input FIFO into system memory. Each instruction can write a run of words to an explicit address, continue writing where the previous write stopped, discard words from the FIFO, wait for a marked word in the FIFO, or branch. A program normally ends by jumping back to its own start, so capture runs as a ring.

Every instruction can set and clear bits of a 4-bit program status field when it completes. That field is mirrored into the top nibble of the interrupt status word. Software reads the field to learn which part of the buffer was finished last. An instruction can also raise the per-line interrupt. A line-length counter reports how many bytes were written between the start-of-line and end-of-line markers. Undefined instructions raise an error bit and halt the engine.

Top module: `cdma_seq`

## Requirements
- R1: After reset, `int_status` and `line_len` are zero, and `rd_en`, `wr_valid` and `fifo_pop` are low.
- R2: When `dma_en` is high and the engine is idle, it fetches its first instruction from `start_addr`. While it executes, bit 27 of `int_status` is 1. One cycle after `dma_en` goes low, bit 27 is 0. While `dma_en` is low there are no fetches, writes or pops. Raising `dma_en` again restarts the program at `start_addr`.
- R3: An instruction is a first word at address A and a second word at A+4. The opcode sits in bits 31:28 of the first word. Opcode 0x1 writes count/4 FIFO words to consecutive word addresses, starting at the second word. The count is taken from bits 11:0 with its two low bits ignored, and a count of 0 writes nothing. Bits 15:12 appear on `wr_be` for every word.
- R4: Opcode 0x5 writes count/4 words, starting at the address just after the last word written.
- R5: Opcode 0x2 pops count/4 FIFO words and writes none of them.
- R6: Opcode 0x7 continues execution at the address held in the second word.
- R7: Opcode 0x8 compares `fifo_mark` with bits 3:0 of the first word. It pops and discards every head word whose mark differs. It completes when the head word matches, and leaves that word in the FIFO.
- R8: When an instruction completes, the status field becomes (status AND NOT bits 23:20) OR bits 19:16. The field is shown in `int_status[31:28]`.
- R9: An instruction with bit 24 set raises `int_status[11]` when it completes. The bit stays set until `clr_line_irq`.
- R10: An opcode other than 0x1, 0x2, 0x5, 0x7 or 0x8, or a first word with bit 25 set, raises `int_status[18]`. The engine then stops: bit 27 is 0 and nothing more is fetched until `dma_en` is cleared and set again. `clr_op_err` clears bit 18.
- R11: A word moves only when `fifo_en` is high and the FIFO is not empty. A pending write keeps its address and data until `wr_ready`. No FIFO word is lost or repeated across stalls.
- R12: Bit 27 of an instruction clears the line byte counter when the instruction starts. Each written word adds 4 to the counter. Bit 26 copies the counter to `line_len` when the instruction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | AW | Byte address of the first instruction |
| dma_en | input | 1 | Run enable for the engine |
| fifo_en | input | 1 | Allows words to be taken from the FIFO |
| rd_en | output | 1 | Instruction read request |
| rd_addr | output | AW | Instruction read byte address |
| rd_data | input | 32 | Read data, valid one cycle after `rd_en` |
| wr_valid | output | 1 | Data write request |
| wr_ready | input | 1 | Memory accepts the write this cycle |
| wr_addr | output | AW | Data write byte address |
| wr_data | output | 32 | Data write word |
| wr_be | output | 4 | Data write byte enables |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | 32 | FIFO head word |
| fifo_mark | input | 4 | Marker carried with the FIFO head word |
| fifo_pop | output | 1 | Removes the FIFO head word |
| clr_line_irq | input | 1 | Clears `int_status[11]` |
| clr_op_err | input | 1 | Clears `int_status[18]` |
| int_status | output | 32 | Status field, running, error and line-interrupt bits |
| line_len | output | LW | Bytes in the last completed line |

## Verification
The in-RTL properties check these on every cycle:
- the engine is silent while it is disabled;
- no pop happens on an empty or disabled FIFO;
- a stalled write holds its address;
- write addresses step by one word;
- a halted engine does not fetch;
- the running bit drops after disable;
- the interrupt and status bits hold when nothing acts on them.

Only the bench scenarios can show the rest:
- the exact addresses, data and byte enables written;
- the order in which the sync instruction discards words;
- the status nibble after a sequence of set and clear masks;
- the line length and the ring wrap through the jump;
- lossless transfer under random write and FIFO stalls.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int WORD_W   = 32;
    localparam int CNT_W    = 12;
    localparam int LEFT_W   = CNT_W - 2;
    localparam int ST_IRQ   = 11;
    localparam int ST_OPERR = 18;
    localparam int ST_RUN   = 27;
    localparam int ST_FLD   = 28;

    localparam logic [3:0] OPC_WRITE  = 4'h1;
    localparam logic [3:0] OPC_SKIP   = 4'h2;
    localparam logic [3:0] OPC_WRITEC = 4'h5;
    localparam logic [3:0] OPC_JUMP   = 4'h7;
    localparam logic [3:0] OPC_SYNC   = 4'h8;

    typedef enum logic [2:0] {
        K_WRITE, K_WRITEC, K_SKIP, K_JUMP, K_SYNC, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic               sol;
        logic               eol;
        logic               irq;
        logic [3:0]         clr_m;
        logic [3:0]         set_m;
        logic [3:0]         be;
        logic [CNT_W-1:0]   count;
    } insn_t;

    typedef enum logic [3:0] {
        S_IDLE, S_F0, S_F1, S_F2, S_XFER, S_SKIP, S_SYNC, S_FIN, S_HALT
    } state_e;

    function automatic insn_t decode_insn(input logic [WORD_W-1:0] w);
        insn_t d;
        d.sol   = w[27];
        d.eol   = w[26];
        d.irq   = w[24];
        d.clr_m = w[23:20];
        d.set_m = w[19:16];
        d.be    = w[15:12];
        d.count = w[CNT_W-1:0];
        case (w[31:28])
            OPC_WRITE:  d.kind = K_WRITE;
            OPC_WRITEC: d.kind = K_WRITEC;
            OPC_SKIP:   d.kind = K_SKIP;
            OPC_JUMP:   d.kind = K_JUMP;
            OPC_SYNC:   d.kind = K_SYNC;
            default:    d.kind = K_BAD;
        endcase
        if (w[25]) d.kind = K_BAD;
        return d;
    endfunction

endpackage

// File: rtl/cdma_ctrl.sv
module cdma_ctrl
    import cdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              fifo_en,
    input  logic [AW-1:0]     start_addr,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [3:0]        wr_be,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic [3:0]        fifo_mark,
    output logic              fifo_pop,
    output logic              running,
    output logic              fin_pulse,
    output logic [3:0]        fin_set,
    output logic [3:0]        fin_clr,
    output logic              fin_irq,
    output logic              fin_eol,
    output logic              sol_pulse,
    output logic              beat,
    output logic              op_err_pulse
);

    localparam logic [AW-1:0] STEP_WORD = AW'(4);
    localparam logic [AW-1:0] STEP_INSN = AW'(8);

    state_e            state;
    logic [AW-1:0]     pc;
    logic [AW-1:0]     cur;
    logic [AW-1:0]     tgt;
    logic [LEFT_W-1:0] left;
    insn_t             ins;
    logic              avail;
    logic              skip_pop;
    logic              sync_hit;
    logic              sync_pop;
    logic              last_word;
    logic [LEFT_W-1:0] words_req;

    always_comb begin
        avail     = dma_en && fifo_en && !fifo_empty;
        rd_en     = dma_en && (state == S_F0 || state == S_F1);
        rd_addr   = (state == S_F1) ? pc + STEP_WORD : pc;
        wr_valid  = (state == S_XFER) && avail;
        wr_addr   = cur;
        wr_data   = fifo_data;
        wr_be     = ins.be;
        beat      = wr_valid && wr_ready;
        skip_pop  = (state == S_SKIP) && avail;
        sync_hit  = (fifo_mark == ins.count[3:0]);
        sync_pop  = (state == S_SYNC) && avail && !sync_hit;
        fifo_pop  = beat || skip_pop || sync_pop;
        last_word = (left == LEFT_W'(1));
        words_req = ins.count[CNT_W-1:2];
        running   = (state != S_IDLE) && (state != S_HALT);
        fin_pulse = (state == S_FIN) && dma_en;
        fin_set   = ins.set_m;
        fin_clr   = ins.clr_m;
        fin_irq   = ins.irq;
        fin_eol   = ins.eol;
        sol_pulse    = (state == S_F2) && dma_en && ins.sol && (ins.kind != K_BAD);
        op_err_pulse = (state == S_F2) && dma_en && (ins.kind == K_BAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            pc    <= '0;
            cur   <= '0;
            tgt   <= '0;
            left  <= '0;
            ins   <= '0;
        end else if (!dma_en) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE: begin
                    pc    <= start_addr;
                    state <= S_F0;
                end
                S_F0: state <= S_F1;
                S_F1: begin
                    ins   <= decode_insn(rd_data);
                    state <= S_F2;
                end
                S_F2: begin
                    left <= words_req;
                    case (ins.kind)
                        K_WRITE: begin
                            cur   <= rd_data[AW-1:0];
                            state <= (words_req == '0) ? S_FIN : S_XFER;
                        end
                        K_WRITEC: state <= (words_req == '0) ? S_FIN : S_XFER;
                        K_SKIP:   state <= (words_req == '0) ? S_FIN : S_SKIP;
                        K_JUMP: begin
                            tgt   <= rd_data[AW-1:0];
                            state <= S_FIN;
                        end
                        K_SYNC:   state <= S_SYNC;
                        default:  state <= S_HALT;
                    endcase
                end
                S_XFER: begin
                    if (beat) begin
                        cur  <= cur + STEP_WORD;
                        left <= left - LEFT_W'(1);
                        if (last_word) state <= S_FIN;
                    end
                end
                S_SKIP: begin
                    if (skip_pop) begin
                        left <= left - LEFT_W'(1);
                        if (last_word) state <= S_FIN;
                    end
                end
                S_SYNC: begin
                    if (avail && sync_hit) state <= S_FIN;
                end
                S_FIN: begin
                    pc    <= (ins.kind == K_JUMP) ? tgt : pc + STEP_INSN;
                    state <= S_F0;
                end
                default: state <= S_HALT;
            endcase
        end
    end

    p_quiet_off_r2: assert property (@(posedge clk) disable iff (rst)
        !dma_en |-> (!rd_en && !wr_valid && !fifo_pop));

    p_pop_has_data_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (!fifo_empty && fifo_en));

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> $stable(wr_addr));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (beat && !last_word) |=> (wr_addr == $past(wr_addr) + STEP_WORD));

    p_halt_no_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT) |-> !rd_en);

endmodule

// File: rtl/cdma_status.sv
module cdma_status
    import cdma_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  logic              fin_pulse,
    input  logic [3:0]        fin_set,
    input  logic [3:0]        fin_clr,
    input  logic              fin_irq,
    input  logic              fin_eol,
    input  logic              sol_pulse,
    input  logic              beat,
    input  logic              op_err_pulse,
    input  logic              clr_line_irq,
    input  logic              clr_op_err,
    output logic [WORD_W-1:0] int_status,
    output logic [LW-1:0]     line_len
);

    localparam logic [LW-1:0] BYTES_PER_BEAT = LW'(4);

    logic [3:0]    stat_q;
    logic          irq_q;
    logic          err_q;
    logic [LW-1:0] line_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= '0;
            irq_q    <= 1'b0;
            err_q    <= 1'b0;
            line_cnt <= '0;
            line_len <= '0;
        end else begin
            if (fin_pulse) stat_q <= (stat_q & ~fin_clr) | fin_set;

            if (fin_pulse && fin_irq) irq_q <= 1'b1;
            else if (clr_line_irq)    irq_q <= 1'b0;

            if (op_err_pulse)    err_q <= 1'b1;
            else if (clr_op_err) err_q <= 1'b0;

            if (sol_pulse)  line_cnt <= '0;
            else if (beat)  line_cnt <= line_cnt + BYTES_PER_BEAT;

            if (fin_pulse && fin_eol) line_len <= line_cnt;
        end
    end

    always_comb begin
        int_status                          = '0;
        int_status[ST_FLD +: 4]             = stat_q;
        int_status[ST_RUN]                  = running;
        int_status[ST_OPERR]                = err_q;
        int_status[ST_IRQ]                  = irq_q;
    end

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr_line_irq) |=> irq_q);

    p_stat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !fin_pulse |=> $stable(stat_q));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_op_err) |=> err_q);

endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
    import cdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     start_addr,
    input  logic              dma_en,
    input  logic              fifo_en,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [31:0]       rd_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [AW-1:0]     wr_addr,
    output logic [31:0]       wr_data,
    output logic [3:0]        wr_be,
    input  logic              fifo_empty,
    input  logic [31:0]       fifo_data,
    input  logic [3:0]        fifo_mark,
    output logic              fifo_pop,
    input  logic              clr_line_irq,
    input  logic              clr_op_err,
    output logic [31:0]       int_status,
    output logic [LW-1:0]     line_len
);

    logic       running;
    logic       fin_pulse;
    logic [3:0] fin_set;
    logic [3:0] fin_clr;
    logic       fin_irq;
    logic       fin_eol;
    logic       sol_pulse;
    logic       beat;
    logic       op_err_pulse;

    cdma_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .dma_en(dma_en), .fifo_en(fifo_en),
        .start_addr(start_addr),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_mark(fifo_mark), .fifo_pop(fifo_pop),
        .running(running), .fin_pulse(fin_pulse),
        .fin_set(fin_set), .fin_clr(fin_clr), .fin_irq(fin_irq),
        .fin_eol(fin_eol), .sol_pulse(sol_pulse), .beat(beat),
        .op_err_pulse(op_err_pulse)
    );

    cdma_status #(.LW(LW)) u_status (
        .clk(clk), .rst(rst), .running(running),
        .fin_pulse(fin_pulse), .fin_set(fin_set), .fin_clr(fin_clr),
        .fin_irq(fin_irq), .fin_eol(fin_eol), .sol_pulse(sol_pulse),
        .beat(beat), .op_err_pulse(op_err_pulse),
        .clr_line_irq(clr_line_irq), .clr_op_err(clr_op_err),
        .int_status(int_status), .line_len(line_len)
    );

    p_run_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !dma_en |=> !int_status[27]);

endmodule

// File: tb/cdma_seq_bench.sv
module cdma_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] start_addr;
    logic        dma_en;
    logic        fifo_en;
    logic        rd_en;
    logic [31:0] rd_addr;
    logic [31:0] rd_data;
    logic        wr_valid;
    logic        wr_ready;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        fifo_empty;
    logic [31:0] fifo_data;
    logic [3:0]  fifo_mark;
    logic        fifo_pop;
    logic        clr_line_irq;
    logic        clr_op_err;
    logic [31:0] int_status;
    logic [15:0] line_len;

    int checks = 0;
    int errors = 0;

    logic [31:0] imem    [0:63];
    logic [31:0] fq_data [0:63];
    logic [3:0]  fq_mark [0:63];
    logic [31:0] wa [0:63];
    logic [31:0] wd [0:63];
    logic [3:0]  wb [0:63];
    int head, tail, nwr, nfetch, nstart;
    logic rnd_mode, fifo_en_req, fen_rand;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdma_seq u_cdma_seq (
        .clk(clk), .rst(rst), .start_addr(start_addr), .dma_en(dma_en),
        .fifo_en(fifo_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_mark(fifo_mark), .fifo_pop(fifo_pop),
        .clr_line_irq(clr_line_irq), .clr_op_err(clr_op_err),
        .int_status(int_status), .line_len(line_len)
    );

    assign fifo_empty = (head >= tail);
    assign fifo_data  = fq_data[head & 63];
    assign fifo_mark  = fq_mark[head & 63];
    assign fifo_en    = fifo_en_req & fen_rand;

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= imem[rd_addr[7:2]];
            nfetch  <= nfetch + 1;
            if (rd_addr == start_addr) nstart <= nstart + 1;
        end
        if (fifo_pop) head <= head + 1;
        if (wr_valid && wr_ready) begin
            wa[nwr & 63] <= wr_addr;
            wd[nwr & 63] <= wr_data;
            wb[nwr & 63] <= wr_be;
            nwr <= nwr + 1;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        wr_ready = 1'b1;
        fen_rand = 1'b1;
        forever begin
            @(negedge clk);
            wr_ready <= rnd_mode ? (($urandom % 4) != 0) : 1'b1;
            fen_rand <= rnd_mode ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input logic sol, input logic eol,
                                       input logic irq, input logic [3:0] clr, input logic [3:0] set,
                                       input logic [3:0] be, input logic [11:0] cnt);
        return {op, sol, eol, 1'b0, irq, clr, set, be, cnt};
    endfunction

    function automatic logic [31:0] ring_addr(input int k);
        if (k < 4)      return 32'h1000 + 32'(4 * k);
        else if (k < 6) return 32'h2000 + 32'(4 * (k - 4));
        else            return 32'h2008 + 32'(4 * (k - 6));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; dma_en = 1'b0; fifo_en_req = 1'b1; rnd_mode = 1'b0;
        clr_line_irq = 1'b0; clr_op_err = 1'b0; start_addr = '0;
        head <= 0; tail <= 0; nwr <= 0; nfetch <= 0; nstart <= 0;
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0; fq_data[i] = 32'h0; fq_mark[i] = 4'h0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_head(input int n, input int maxc);
        for (int c = 0; c < maxc && head < n; c++) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) clr_line_irq = 1'b1; else clr_op_err = 1'b1;
        @(negedge clk);
        clr_line_irq = 1'b0; clr_op_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_ring(input logic rnd);
        do_reset();
        imem[0]  = 32'h8000_0006;                                  imem[1]  = 0;
        imem[2]  = mk(4'h1, 1, 1, 1, 4'hE, 4'h1, 4'hF, 12'd16);    imem[3]  = 32'h1000;
        imem[4]  = mk(4'h1, 1, 0, 0, 4'h0, 4'h2, 4'hF, 12'd8);     imem[5]  = 32'h2000;
        imem[6]  = mk(4'h5, 0, 1, 1, 4'h1, 4'h0, 4'hF, 12'd12);    imem[7]  = 0;
        imem[8]  = mk(4'h2, 0, 0, 0, 4'h0, 4'h0, 4'h0, 12'd8);     imem[9]  = 0;
        imem[10] = 32'h8000_000C;                                  imem[11] = 0;
        imem[12] = 32'h7000_0000;                                  imem[13] = 32'h0;
        for (int i = 0; i < 13; i++)
            fq_data[i] = rnd ? $urandom : (32'hA500_0000 + 32'(i));
        fq_mark[0] = 4'h3; fq_mark[1] = 4'h6; fq_mark[12] = 4'hC;
        @(negedge clk);
        tail <= 13;
        rnd_mode = rnd;
        dma_en = 1'b1;
        wait_head(13, 3000);
        repeat (30) @(negedge clk);
        chk("R11 all FIFO words consumed", 32'(head), 32'd13);
        chk("R3 R4 R5 write count", 32'(nwr), 32'd9);
        for (int k = 0; k < 9; k++) begin
            chk("R3 R4 write address", wa[k], ring_addr(k));
            chk("R7 R11 write data order", wd[k], fq_data[k + 1]);
            chk("R3 byte enables", {28'h0, wb[k]}, 32'hF);
        end
        chk("R8 status field", {28'h0, int_status[31:28]}, 32'h2);
        chk("R9 line irq raised", {31'h0, int_status[11]}, 32'h1);
        chk("R2 running bit while waiting", {31'h0, int_status[27]}, 32'h1);
        chk("R12 line length", {16'h0, line_len}, 32'd20);
        chk("R6 ring wrapped to start", 32'(nstart), 32'd2);
        pulse(0);
        chk("R9 line irq cleared", {31'h0, int_status[11]}, 32'h0);
        @(negedge clk);
        dma_en = 1'b0;
        rnd_mode = 1'b0;
        @(negedge clk);
        chk("R2 running cleared", {31'h0, int_status[27]}, 32'h0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        rst = 1'b1;
        do_reset();
        @(negedge clk);
        chk("R1 int_status reset", int_status, 32'h0);
        chk("R1 line_len reset", {16'h0, line_len}, 32'h0);
        chk("R1 outputs idle", {29'h0, rd_en, wr_valid, fifo_pop}, 32'h0);

        run_ring(1'b0);
        run_ring(1'b1);

        // short write, zero count, then invalid opcode
        do_reset();
        start_addr = 32'h40;
        imem[16] = mk(4'h1, 0, 0, 0, 4'h0, 4'h0, 4'h3, 12'd6);  imem[17] = 32'h500;
        imem[18] = mk(4'h1, 0, 0, 1, 4'h0, 4'h4, 4'hF, 12'd0);  imem[19] = 32'h600;
        imem[20] = 32'h3000_0000;                               imem[21] = 0;
        fq_data[0] = 32'h1111_2222; fq_data[1] = 32'h3333_4444;
        @(negedge clk);
        tail <= 2;
        dma_en = 1'b1;
        repeat (40) @(negedge clk);
        chk("R3 count 6 gives one word", 32'(nwr), 32'd1);
        chk("R3 short write address", wa[0], 32'h500);
        chk("R3 short write data", wd[0], 32'h1111_2222);
        chk("R3 byte enable field", {28'h0, wb[0]}, 32'h3);
        chk("R3 zero count pops nothing", 32'(head), 32'd1);
        chk("R8 set mask applied", {28'h0, int_status[31:28]}, 32'h4);
        chk("R9 irq from zero-count write", {31'h0, int_status[11]}, 32'h1);
        chk("R10 opcode error raised", {31'h0, int_status[18]}, 32'h1);
        chk("R10 halted not running", {31'h0, int_status[27]}, 32'h0);
        f0 = nfetch;
        repeat (20) @(negedge clk);
        chk("R10 no fetch after halt", 32'(nfetch), 32'(f0));
        pulse(1);
        chk("R10 opcode error cleared", {31'h0, int_status[18]}, 32'h0);

        // reserved bit 25 also invalid
        do_reset();
        imem[0] = 32'h1200_0004; imem[1] = 32'h700;
        @(negedge clk);
        dma_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10 reserved bit error", {31'h0, int_status[18]}, 32'h1);

        // FIFO gating, stall, disable and restart
        do_reset();
        start_addr = 32'h80;
        imem[32] = mk(4'h1, 0, 0, 0, 4'h0, 4'h0, 4'hF, 12'd16); imem[33] = 32'h3000;
        for (int i = 0; i < 8; i++) fq_data[i] = 32'hC0DE_0000 + 32'(i);
        fifo_en_req = 1'b0;
        @(negedge clk);
        tail <= 2;
        dma_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R11 no pop with fifo disabled", 32'(head), 32'd0);
        chk("R11 no write with fifo disabled", 32'(nwr), 32'd0);
        fifo_en_req = 1'b1;
        repeat (20) @(negedge clk);
        chk("R11 writes stop at empty FIFO", 32'(nwr), 32'd2);
        chk("R2 running while stalled", {31'h0, int_status[27]}, 32'h1);
        dma_en = 1'b0;
        @(negedge clk);
        chk("R2 running drops after disable", {31'h0, int_status[27]}, 32'h0);
        tail <= 4;
        f0 = nstart;
        repeat (10) @(negedge clk);
        chk("R2 no pop while disabled", 32'(head), 32'd2);
        chk("R2 no write while disabled", 32'(nwr), 32'd2);
        dma_en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R2 refetch from start address", 32'(nstart), 32'(f0 + 1));
        chk("R2 restart rewrites from base", wa[2], 32'h3000);
        chk("R11 restart data continues", wd[2], 32'hC0DE_0002);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule